// File: doc/BRIEF.md
# Coded Flit Receive Decoder

This block sits at a router input, right after the link. The upstream switch fabric does not wait for its arbiter. When several flits collide on an output, it sends their XOR. Each word that arrives carries a one-bit flag saying whether it is coded. The decoder keeps the arriving words in a small circular buffer and turns them back into plain flits for the logic downstream.

A collision group of plain flits P1..Pk arrives as k words: P1^P2^..^Pk, then P2^..^Pk, and so on down to Pk. Only the last word of the group is sent uncoded. XORing any coded word with the word that follows it recovers one plain flit. The flits come out in the order the upstream arbiter picked its winners, so that arbiter's fairness carries through the link. An uncoded word at the head of the buffer is presented at once. A coded head waits until its successor is stored. Decoding takes a single XOR stage, whatever the port count of the router.

Upstream must not send while the full indication is raised. Downstream takes flits through a valid/ready handshake.

Top module: `cfd_rx_decoder`

## Requirements
- R1: When the head entry is uncoded (coded flag 0), `out_valid_o` is high in every cycle that entry is stored, and `out_data_o` equals the stored word with no added cycle; with the buffer empty `out_valid_o` is low.
- R2: When the head entry is coded (coded flag 1), `out_valid_o` stays low until a second entry is stored; from then on `out_data_o` equals the head word XOR the next stored word.
- R3: The head entry leaves the buffer only in a cycle where `out_valid_o` and `out_ready_i` are both high; while `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged in the next cycle.
- R4: A collision group sent as words P1^..^Pk (coded), P2^..^Pk (coded), ..., Pk (uncoded) is delivered as the plain flits P1, P2, ..., Pk in that order, and successive groups are delivered in arrival order.
- R5: `link_full_o` is high exactly when DEPTH entries are stored; a word offered while `link_full_o` is high is ignored and changes neither the buffer nor the outputs.
- R6: After reset the buffer is empty: `out_valid_o` and `link_full_o` are low.
- R7: A word offered with `link_full_o` low is stored in that same clock edge, also when a flit is taken out in the same cycle, so the occupancy changes by the number of words in minus the number of flits out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_valid_i | input | 1 | A word is present on the link |
| link_coded_i | input | 1 | 1: the word is an XOR of several flits; 0: plain flit |
| link_data_i | input | DATA_W | Link word |
| link_full_o | output | 1 | Buffer full, upstream must hold off |
| out_valid_o | output | 1 | A decoded flit is presented |
| out_ready_i | input | 1 | Downstream accepts the presented flit |
| out_data_o | output | DATA_W | Decoded plain flit |

## Verification
The bench builds the block with 64-bit words and a four-entry buffer. These are the defaults, and the power-of-two depth selects the free-wrapping pointer variant. With four entries, a phase with a rarely ready output reaches the full state within a few cycles. Collision groups of up to six words are longer than the buffer, so a full buffer of only coded words still has to drain through decoding. Ignored words offered against a full buffer are also reached often.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   // What the entry at the head of the buffer allows the output to do
   typedef enum logic [1:0] {
      HEAD_EMPTY       = 2'd0,
      HEAD_PLAIN       = 2'd1,
      HEAD_CODED_WAIT  = 2'd2,
      HEAD_CODED_READY = 2'd3
   } head_kind_e;

endpackage

// File: rtl/cfd_store.sv
module cfd_store #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              push_coded,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              head_coded,
   output logic [DATA_W-1:0] next_data,
   output logic [OCC_W-1:0]  occ,
   output logic              full
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [DATA_W:0]  mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_inc, rd_inc;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_inc = wr_ptr + PTR_W'(1);
         assign rd_inc = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= {push_coded, push_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= wr_inc;
         if (pop)  rd_ptr <= rd_inc;
         case ({push, pop})
            2'b10:   occ <= occ + OCC_W'(1);
            2'b01:   occ <= occ - OCC_W'(1);
            default: occ <= occ;
         endcase
      end
   end

   assign head_data  = mem[rd_ptr][DATA_W-1:0];
   assign head_coded = mem[rd_ptr][DATA_W];
   assign next_data  = mem[rd_inc][DATA_W-1:0];
   assign full       = (occ == OCC_W'(DEPTH));

endmodule

// File: rtl/cfd_decode.sv
module cfd_decode
   import cfd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int OCC_W  = 3
) (
   input  logic [DATA_W-1:0] head_data,
   input  logic              head_coded,
   input  logic [DATA_W-1:0] next_data,
   input  logic [OCC_W-1:0]  occ,
   output head_kind_e        kind,
   output logic              valid,
   output logic [DATA_W-1:0] data
);

   always_comb begin
      if (occ == '0)
         kind = HEAD_EMPTY;
      else if (!head_coded)
         kind = HEAD_PLAIN;
      else if (occ >= OCC_W'(2))
         kind = HEAD_CODED_READY;
      else
         kind = HEAD_CODED_WAIT;
   end

   // One XOR stage, independent of how many words were combined upstream
   assign valid = (kind == HEAD_PLAIN) || (kind == HEAD_CODED_READY);
   assign data  = (kind == HEAD_CODED_READY) ? (head_data ^ next_data) : head_data;

endmodule

// File: rtl/cfd_rx_decoder.sv
module cfd_rx_decoder
   import cfd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_valid_i,
   input  logic              link_coded_i,
   input  logic [DATA_W-1:0] link_data_i,
   output logic              link_full_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [DATA_W-1:0] out_data_o
);

   localparam int OCC_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfd_rx_decoder: DEPTH must be at least 2 to pair a coded word");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("cfd_rx_decoder: DATA_W must be positive");
      end
   endgenerate

   logic              push, pop;
   logic [DATA_W-1:0] head_data, next_data;
   logic              head_coded;
   logic [OCC_W-1:0]  occ;
   head_kind_e        head_kind;

   assign push = link_valid_i && !link_full_o;
   assign pop  = out_valid_o && out_ready_i;

   cfd_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_coded (link_coded_i),
      .push_data  (link_data_i),
      .pop        (pop),
      .head_data  (head_data),
      .head_coded (head_coded),
      .next_data  (next_data),
      .occ        (occ),
      .full       (link_full_o)
   );

   cfd_decode #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_decode (
      .head_data  (head_data),
      .head_coded (head_coded),
      .next_data  (next_data),
      .occ        (occ),
      .kind       (head_kind),
      .valid      (out_valid_o),
      .data       (out_data_o)
   );

endmodule

// File: rtl/cfd_rx_decoder_chk.sv
module cfd_rx_decoder_chk #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_valid_i,
   input logic              link_full_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] out_data_o,
   input logic              head_coded,
   input logic [OCC_W-1:0]  occ
);

   assert_reset_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid_o && !link_full_o));

   assert_empty_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !out_valid_o);

   assert_coded_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (head_coded && occ < OCC_W'(2)) |-> !out_valid_o);

   assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_full_o && !(out_valid_o && out_ready_i)) |=> link_full_o);

   assert_store_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid_i && !link_full_o && !(out_valid_o && out_ready_i))
      |=> (occ == $past(occ) + OCC_W'(1)));

endmodule

bind cfd_rx_decoder cfd_rx_decoder_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .link_valid_i (link_valid_i),
   .link_full_o  (link_full_o),
   .out_valid_o  (out_valid_o),
   .out_ready_i  (out_ready_i),
   .out_data_o   (out_data_o),
   .head_coded   (head_coded),
   .occ          (occ)
);

// File: tb/sim_cfd_rx_decoder.sv
module sim_cfd_rx_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 64;
   localparam int DEPTH      = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              link_valid = 1'b0, link_coded = 1'b0;
   logic [DATA_W-1:0] link_data = '0;
   logic              link_full, out_valid, out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;

   cfd_rx_decoder #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .link_valid_i(link_valid), .link_coded_i(link_coded),
      .link_data_i(link_data), .link_full_o(link_full), .out_valid_o(out_valid),
      .out_ready_i(out_ready), .out_data_o(out_data));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct { bit c; logic [DATA_W-1:0] d; } word_t;
   word_t             mq[$];  // model of stored words
   word_t             sq[$];  // words waiting to be sent
   logic [DATA_W-1:0] eq[$];  // plain flits expected, in arbiter order

   int errors = 0, checks = 0;
   bit pend_pop = 0, pend_push = 0, hold_prev = 0;
   logic [DATA_W-1:0] hold_data = '0;

   task automatic chk(bit ok, string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] rnd_word();
      return {$urandom, $urandom};
   endfunction

   task automatic make_group(int k);
      logic [DATA_W-1:0] p[];
      p = new[k];
      for (int i = 0; i < k; i++) begin
         p[i] = rnd_word();
         eq.push_back(p[i]);
      end
      for (int i = 0; i < k; i++) begin
         logic [DATA_W-1:0] acc = '0;
         for (int j = i; j < k; j++) acc ^= p[j];
         sq.push_back('{c: (i < k - 1), d: acc});
      end
   endtask

   task automatic step(int rdy_pct, int val_pct, bit allow_junk, bit feed);
      bit mv, mf, junk;
      logic [DATA_W-1:0] md;
      string tag;
      @(negedge clk);
      if (pend_pop) void'(mq.pop_front());
      if (pend_push) mq.push_back(sq.pop_front());
      mv = 0; md = '0;
      if (mq.size() > 0) begin
         md = mq[0].d;
         if (mq[0].c) begin
            mv = (mq.size() >= 2);
            if (mv) md = mq[0].d ^ mq[1].d;
         end else mv = 1;
      end
      mf  = (mq.size() == DEPTH);
      tag = (mq.size() > 0 && mq[0].c) ? "R2" : "R1";
      chk(out_valid == mv, tag, "out_valid", DATA_W'(out_valid), DATA_W'(mv));
      if (mv) chk(out_data == md, tag, "out_data", out_data, md);
      chk(link_full == mf, "R5", "link_full", DATA_W'(link_full), DATA_W'(mf));
      if (hold_prev) chk(out_data == hold_data, "R3", "stalled data", out_data, hold_data);

      if (feed && sq.size() < 8) make_group(1 + $urandom_range(0, 5));
      out_ready = ($urandom_range(0, 99) < rdy_pct);
      junk = 0;
      if (sq.size() > 0 && $urandom_range(0, 99) < val_pct) begin
         link_valid = 1'b1;
         link_coded = sq[0].c;
         link_data  = sq[0].d;
         if (allow_junk && mf && $urandom_range(0, 1) == 1) begin
            // R5: offered against a full buffer, must leave no trace
            link_data  = rnd_word();
            link_coded = $urandom_range(0, 1) == 1;
            junk = 1;
         end
      end else begin
         link_valid = 1'b0;
         link_coded = 1'b0;
         link_data  = '0;
      end
      pend_pop  = mv && out_ready;
      pend_push = link_valid && !mf && !junk;
      if (pend_pop) begin
         if (eq.size() == 0) chk(0, "R4", "unexpected flit", out_data, '0);
         else begin
            logic [DATA_W-1:0] e = eq.pop_front();
            chk(out_data == e, "R4", "delivered order", out_data, e);
         end
      end
      hold_prev = mv && !out_ready;
      hold_data = md;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R6", "reset out_valid", DATA_W'(out_valid), '0);
      chk(link_full == 1'b0, "R6", "reset link_full", DATA_W'(link_full), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", "idle out_valid", DATA_W'(out_valid), '0);
      chk(link_full == 1'b0, "R6", "idle link_full", DATA_W'(link_full), '0);
      // R1/R7: ready downstream, steady traffic with push and pop together
      repeat (300)  step(100, 70, 1'b0, 1'b1);
      // R5/R2: downstream mostly stalled, buffer fills with coded words
      repeat (300)  step(5, 90, 1'b1, 1'b1);
      // R3/R4: mixed stalls and gaps
      repeat (1200) step(50, 50, 1'b1, 1'b1);
      for (int n = 0; n < 2000 && (mq.size() > 0 || sq.size() > 0); n++)
         step(100, 100, 1'b0, 1'b0);
      chk(mq.size() == 0 && sq.size() == 0, "R4", "drained", DATA_W'(mq.size() + sq.size()), '0);
      chk(eq.size() == 0, "R4", "all flits delivered", DATA_W'(eq.size()), '0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "empty out_valid", DATA_W'(out_valid), '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule